// File: doc/BRIEF.md
# Quad-Lane-Preserving Fragment Vector Compactor

The compactor sits between rasterization and fragment shading. Each micro triangle tends to leave a 2x2 pixel quad with only one or two live fragments, so the SIMD vectors coming out of rasterization are sparse. The block parks up to four such sparse vectors in a small queue. When the queue fills, or when a flush is requested, it merges the live fragment threads into as few dense vectors as it can. It then hands those vectors to the scheduler one per cycle and hands the queue slots back.

Compaction never moves a thread to a different pixel position inside a quad. A fragment that arrived in lane `q*4+p` always leaves in some lane `q'*4+p`. The register file is banked by quad position, so no register value ever crosses a bank. Every output lane carries the thread ID, a valid bit and the index of the queue slot the thread came from. Downstream logic can therefore trace the thread back to its origin. The merged vectors mix quads from different triangles freely.

Top module: `quad_compactor`

## Requirements
- R1: After reset, in_ready_o is 1, out_valid_o is 0 and free_o is 0.
- R2: While in_ready_o is 1, a vector offered with in_valid_i is stored in the next queue slot, and slots fill in arrival order starting at slot 0. No output vector appears until the fence releases.
- R3: The fence releases when the fourth vector is stored, or when flush_i is high with at least one vector stored (this includes a vector stored in that same cycle). A flush with an empty queue has no effect.
- R4: A thread taken from input lane q*4+p is emitted in an output lane q'*4+p, meaning its quad position p (lane index mod 4) is kept.
- R5: For each quad position, valid threads are ranked in arrival order: by slot first, then by input quad ascending. Rank r goes to output vector r/4, in output quad r mod 4.
- R6: The number of output vectors equals the largest per-position valid count divided by 4, rounded up. They are emitted on consecutive cycles, starting in the cycle after the release. Unused lanes have valid 0, thread ID 0 and source 0.
- R7: Each valid output lane reports, in out_src_o, the queue slot (0 to 3) of its source vector.
- R8: free_o pulses for one cycle together with the last output vector, or alone in the cycle after the release if no thread was valid. During that pulse, free_mask_o has bit s set for every slot s that was in use. in_ready_o is 1 again in the next cycle.
- R9: Four fully dense input vectors come out unchanged and in arrival order.
- R10: in_ready_o is 0 from the release until the cycle after free_o. A vector offered during that time is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sparse vector offered |
| in_lane_vld_i | input | 16 | Per-lane thread valid |
| in_tid_i | input | 128 | Per-lane thread ID, 8 bits per lane, lane 0 in the low bits |
| flush_i | input | 1 | Release the fence early |
| in_ready_o | output | 1 | Queue accepting vectors |
| out_valid_o | output | 1 | Dense vector present |
| out_lane_vld_o | output | 16 | Per-lane valid of the dense vector |
| out_tid_o | output | 128 | Per-lane thread ID |
| out_src_o | output | 32 | Per-lane source slot, 2 bits per lane |
| free_o | output | 1 | Queue slots released |
| free_mask_o | output | 4 | Slots released this cycle |

## Verification
Two pairs of events can land in the same cycle. The first pair is a flush and the storing of the vector that goes with it. The bench provokes this by asserting flush_i in the same cycle as the last offered vector, in queues of one and two vectors. It judges the result by whether that vector's threads appear in the merged output. The second pair is the final dense vector and the slot release. Every scenario checks free_o and free_mask_o on each emitted vector, so the pulse must come exactly on the last one. An all-empty queue covers the case where the release has no vector to travel with. A vector offered in the release cycle must be dropped, and the next compaction must show no trace of it.

// File: rtl/vcomp_pkg.sv
package vcomp_pkg;
  localparam int QUAD_SIZE = 4;
  typedef enum logic {ST_FILL = 1'b0, ST_DRAIN = 1'b1} vc_state_e;
endpackage

// File: rtl/vcomp_queue.sv
module vcomp_queue #(
  parameter int DEPTH  = 4,
  parameter int LANES  = 16,
  parameter int TID_W  = 8,
  parameter int SLOT_W = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [SLOT_W-1:0]            wr_slot_i,
  input  logic [LANES-1:0]             wr_vld_i,
  input  logic [LANES*TID_W-1:0]       wr_tid_i,
  input  logic                         clr_i,
  output logic [DEPTH*LANES-1:0]       vld_o,
  output logic [DEPTH*LANES*TID_W-1:0] tid_o
);
  for (genvar v = 0; v < DEPTH; v++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_slot_i == SLOT_W'(v));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    vld_o[v*LANES +: LANES] <= '0;
      else if (clr_i) vld_o[v*LANES +: LANES] <= '0;
      else if (hit)   vld_o[v*LANES +: LANES] <= wr_vld_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  tid_o[v*LANES*TID_W +: LANES*TID_W] <= '0;
      else if (hit) tid_o[v*LANES*TID_W +: LANES*TID_W] <= wr_tid_i;
    end
  end
endmodule

// File: rtl/vcomp_rank.sv
module vcomp_rank
  import vcomp_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int NUM_QUADS = 4,
  parameter int RANK_W    = 5,
  localparam int LANES    = NUM_QUADS * QUAD_SIZE
) (
  input  logic [DEPTH*LANES-1:0]        vld_i,
  output logic [DEPTH*LANES*RANK_W-1:0] rank_o,
  output logic [QUAD_SIZE*RANK_W-1:0]   cnt_o
);
  // per quad position: running count in slot-major, quad-minor order
  for (genvar p = 0; p < QUAD_SIZE; p++) begin : g_pos
    always_comb begin
      logic [RANK_W-1:0] acc;
      acc = '0;
      for (int v = 0; v < DEPTH; v++) begin
        for (int q = 0; q < NUM_QUADS; q++) begin
          rank_o[(v*LANES + q*QUAD_SIZE + p)*RANK_W +: RANK_W] = acc;
          if (vld_i[v*LANES + q*QUAD_SIZE + p]) acc = acc + RANK_W'(1);
        end
      end
      cnt_o[p*RANK_W +: RANK_W] = acc;
    end
  end
endmodule

// File: rtl/vcomp_select.sv
module vcomp_select
  import vcomp_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int NUM_QUADS = 4,
  parameter int TID_W     = 8,
  parameter int RANK_W    = 5,
  parameter int SLOT_W    = 2,
  parameter int OUT_W     = 3,
  localparam int LANES    = NUM_QUADS * QUAD_SIZE
) (
  input  logic [DEPTH*LANES-1:0]        vld_i,
  input  logic [DEPTH*LANES*TID_W-1:0]  tid_i,
  input  logic [DEPTH*LANES*RANK_W-1:0] rank_i,
  input  logic [OUT_W-1:0]              out_idx_i,
  output logic [LANES-1:0]              lane_vld_o,
  output logic [LANES*TID_W-1:0]        lane_tid_o,
  output logic [LANES*SLOT_W-1:0]       lane_src_o
);
  for (genvar oq = 0; oq < NUM_QUADS; oq++) begin : g_oq
    for (genvar p = 0; p < QUAD_SIZE; p++) begin : g_pos
      localparam int OL = oq*QUAD_SIZE + p;
      logic              s_vld;
      logic [TID_W-1:0]  s_tid;
      logic [SLOT_W-1:0] s_src;
      logic [RANK_W-1:0] target;

      assign target = RANK_W'(int'(out_idx_i) * NUM_QUADS + oq);

      // only candidates at the same quad position are considered
      always_comb begin
        s_vld = 1'b0;
        s_tid = '0;
        s_src = '0;
        for (int v = 0; v < DEPTH; v++) begin
          for (int q = 0; q < NUM_QUADS; q++) begin
            if (vld_i[v*LANES + q*QUAD_SIZE + p] &&
                rank_i[(v*LANES + q*QUAD_SIZE + p)*RANK_W +: RANK_W] == target) begin
              s_vld = 1'b1;
              s_tid = tid_i[(v*LANES + q*QUAD_SIZE + p)*TID_W +: TID_W];
              s_src = SLOT_W'(v);
            end
          end
        end
      end

      assign lane_vld_o[OL]                 = s_vld;
      assign lane_tid_o[OL*TID_W +: TID_W]  = s_tid;
      assign lane_src_o[OL*SLOT_W +: SLOT_W] = s_src;
    end
  end
endmodule

// File: rtl/quad_compactor.sv
module quad_compactor
  import vcomp_pkg::*;
#(
  parameter int NUM_QUADS = 4,
  parameter int DEPTH     = 4,
  parameter int TID_W     = 8,
  localparam int LANES    = NUM_QUADS * QUAD_SIZE,
  localparam int SLOT_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int RANK_W   = $clog2(DEPTH*NUM_QUADS + 1),
  localparam int OUT_W    = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [LANES-1:0]        in_lane_vld_i,
  input  logic [LANES*TID_W-1:0]  in_tid_i,
  input  logic                    flush_i,
  output logic                    in_ready_o,
  output logic                    out_valid_o,
  output logic [LANES-1:0]        out_lane_vld_o,
  output logic [LANES*TID_W-1:0]  out_tid_o,
  output logic [LANES*SLOT_W-1:0] out_src_o,
  output logic                    free_o,
  output logic [DEPTH-1:0]        free_mask_o
);
  vc_state_e               state_q;
  logic [CNT_W-1:0]        fill_q, fill_nxt;
  logic [OUT_W-1:0]        out_idx_q, n_out;
  logic                    accept, fire, last;
  logic [DEPTH*LANES-1:0]  q_vld;
  logic [DEPTH*LANES*TID_W-1:0]  q_tid;
  logic [DEPTH*LANES*RANK_W-1:0] rank;
  logic [QUAD_SIZE*RANK_W-1:0]   pos_cnt;
  logic [RANK_W-1:0]       max_cnt;

  assign in_ready_o = (state_q == ST_FILL);
  assign accept     = in_valid_i && in_ready_o;
  assign fill_nxt   = fill_q + CNT_W'(accept);
  assign fire       = in_ready_o &&
                      (fill_nxt == CNT_W'(DEPTH) || (flush_i && fill_nxt != '0));
  assign last       = (state_q == ST_DRAIN) &&
                      ((OUT_W+1)'(out_idx_q) + (OUT_W+1)'(1) >= (OUT_W+1)'(n_out));

  vcomp_queue #(
    .DEPTH(DEPTH), .LANES(LANES), .TID_W(TID_W), .SLOT_W(SLOT_W)
  ) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (accept),
    .wr_slot_i (fill_q[SLOT_W-1:0]),
    .wr_vld_i  (in_lane_vld_i),
    .wr_tid_i  (in_tid_i),
    .clr_i     (last),
    .vld_o     (q_vld),
    .tid_o     (q_tid)
  );

  vcomp_rank #(
    .DEPTH(DEPTH), .NUM_QUADS(NUM_QUADS), .RANK_W(RANK_W)
  ) u_rank (
    .vld_i  (q_vld),
    .rank_o (rank),
    .cnt_o  (pos_cnt)
  );

  always_comb begin
    max_cnt = '0;
    for (int p = 0; p < QUAD_SIZE; p++)
      if (pos_cnt[p*RANK_W +: RANK_W] > max_cnt) max_cnt = pos_cnt[p*RANK_W +: RANK_W];
  end
  assign n_out = OUT_W'((int'(max_cnt) + NUM_QUADS - 1) / NUM_QUADS);

  vcomp_select #(
    .DEPTH(DEPTH), .NUM_QUADS(NUM_QUADS), .TID_W(TID_W),
    .RANK_W(RANK_W), .SLOT_W(SLOT_W), .OUT_W(OUT_W)
  ) u_select (
    .vld_i      (q_vld),
    .tid_i      (q_tid),
    .rank_i     (rank),
    .out_idx_i  (out_idx_q),
    .lane_vld_o (out_lane_vld_o),
    .lane_tid_o (out_tid_o),
    .lane_src_o (out_src_o)
  );

  assign out_valid_o = (state_q == ST_DRAIN) && (out_idx_q < n_out);
  assign free_o      = last;
  for (genvar s = 0; s < DEPTH; s++) begin : g_free
    assign free_mask_o[s] = last && (CNT_W'(s) < fill_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FILL;
      fill_q    <= '0;
      out_idx_q <= '0;
    end else if (last) begin
      state_q   <= ST_FILL;
      fill_q    <= '0;
      out_idx_q <= '0;
    end else if (state_q == ST_DRAIN) begin
      out_idx_q <= out_idx_q + OUT_W'(1);
    end else begin
      fill_q <= fill_nxt;
      if (fire) begin
        state_q   <= ST_DRAIN;
        out_idx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/quad_compactor_chk.sv
module quad_compactor_chk #(
  parameter int LANES  = 16,
  parameter int DEPTH  = 4,
  parameter int TID_W  = 8,
  parameter int SLOT_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    in_valid_i,
  input logic                    flush_i,
  input logic                    in_ready_o,
  input logic                    out_valid_o,
  input logic [LANES-1:0]        out_lane_vld_o,
  input logic [LANES*TID_W-1:0]  out_tid_o,
  input logic [LANES*SLOT_W-1:0] out_src_o,
  input logic                    free_o,
  input logic [DEPTH-1:0]        free_mask_o
);
  a_r10_no_ready_while_emitting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r6_vector_carries_thread: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_lane_vld_o != '0);

  a_r8_ready_after_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |=> in_ready_o);

  a_r8_free_has_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |-> free_mask_o != '0);

  a_r8_no_output_after_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_o |=> !out_valid_o);

  a_r3_release_from_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_ready_o));

  for (genvar oq = 1; oq < LANES/4; oq++) begin : g_pack
    for (genvar p = 0; p < 4; p++) begin : g_pos
      a_r5_lowest_quad_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_lane_vld_o[oq*4+p]) |-> out_lane_vld_o[(oq-1)*4+p]);
    end
  end
endmodule

bind quad_compactor quad_compactor_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .TID_W(TID_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_valid_i     (in_valid_i),
  .flush_i        (flush_i),
  .in_ready_o     (in_ready_o),
  .out_valid_o    (out_valid_o),
  .out_lane_vld_o (out_lane_vld_o),
  .out_tid_o      (out_tid_o),
  .out_src_o      (out_src_o),
  .free_o         (free_o),
  .free_mask_o    (free_mask_o)
);

// File: tb/quad_compactor_tb_top.sv
`timescale 1ns/1ps
module quad_compactor_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [15:0]  in_vld = '0;
  logic [127:0] in_tid = '0;
  logic         flush = 1'b0;
  logic         in_ready, out_valid, free_p;
  logic [15:0]  out_vld;
  logic [127:0] out_tid;
  logic [31:0]  out_src;
  logic [3:0]   free_mask;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  quad_compactor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_lane_vld_i(in_vld),
    .in_tid_i(in_tid), .flush_i(flush), .in_ready_o(in_ready), .out_valid_o(out_valid),
    .out_lane_vld_o(out_vld), .out_tid_o(out_tid), .out_src_o(out_src),
    .free_o(free_p), .free_mask_o(free_mask)
  );

  typedef struct packed {
    logic [2:0]       nvec;
    logic [3:0][15:0] mask;
  } scen_t;

  localparam int NSCEN = 7;
  localparam scen_t SCEN [NSCEN] = '{
    '{3'd4, 64'h0008_0004_0002_0001},
    '{3'd4, 64'hFFFF_FFFF_FFFF_FFFF},
    '{3'd4, 64'h1111_1111_1111_1111},
    '{3'd2, 64'h0000_0000_8400_0021},
    '{3'd4, 64'hF000_0F0F_AAAA_1357},
    '{3'd4, 64'h0000_0000_0000_0000},
    '{3'd1, 64'h0000_0000_0000_0010}
  };

  task automatic check_eq(string tag, logic [191:0] act, logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] tids_for(int slot);
    logic [127:0] t;
    for (int l = 0; l < 16; l++) t[l*8 +: 8] = 8'(slot*16 + l);
    return t;
  endfunction

  task automatic run_scen(int nvec, logic [3:0][15:0] masks, string tag);
    logic [15:0]  ev [4];
    logic [127:0] et [4];
    logic [31:0]  es [4];
    int cnt [4];
    int mx, n;
    for (int k = 0; k < 4; k++) begin ev[k] = '0; et[k] = '0; es[k] = '0; cnt[k] = 0; end
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < nvec; v++)
        for (int q = 0; q < 4; q++)
          if (masks[v][q*4+p]) begin
            int ok, ol;
            ok = cnt[p] / 4;
            ol = (cnt[p] % 4) * 4 + p;
            ev[ok][ol] = 1'b1;
            et[ok][ol*8 +: 8] = 8'(v*16 + q*4 + p);
            es[ok][ol*2 +: 2] = 2'(v);
            cnt[p]++;
          end
    mx = 0;
    for (int p = 0; p < 4; p++) if (cnt[p] > mx) mx = cnt[p];
    n = (mx + 3) / 4;

    for (int v = 0; v < nvec; v++) begin
      @(negedge clk);
      check_eq({tag, " R2 fence holds"}, {190'd0, in_ready, out_valid}, {190'd0, 1'b1, 1'b0});
      in_valid = 1'b1;
      in_vld   = masks[v];
      in_tid   = tids_for(v);
      flush    = (v == nvec-1) && (nvec < 4);
    end
    @(negedge clk);
    in_valid = 1'b0;
    flush    = 1'b0;
    if (n == 0) begin
      check_eq({tag, " R8 empty release"}, {186'd0, out_valid, free_p, free_mask},
               {186'd0, 1'b0, 1'b1, 4'((1 << nvec) - 1)});
    end else begin
      for (int k = 0; k < n; k++) begin
        if (k > 0) @(negedge clk);
        check_eq({tag, " R4 R5 R6 R7 R8 dense vector"},
                 {10'd0, out_valid, free_p, free_mask, out_vld, out_tid, out_src},
                 {10'd0, 1'b1, (k == n-1), (k == n-1) ? 4'((1 << nvec) - 1) : 4'd0,
                  ev[k], et[k], es[k]});
      end
    end
    @(negedge clk);
    check_eq({tag, " R8 R10 ready after release"}, {190'd0, in_ready, out_valid},
             {190'd0, 1'b1, 1'b0});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_eq("R1 reset state", {189'd0, in_ready, out_valid, free_p}, {189'd0, 3'b100});
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 after reset", {189'd0, in_ready, out_valid, free_p}, {189'd0, 3'b100});

    for (int i = 0; i < NSCEN; i++)
      run_scen(int'(SCEN[i].nvec), SCEN[i].mask, (i == 1) ? "R9 dense pass" : "table");

    // R3: flush with nothing queued
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check_eq("R3 empty flush ignored", {189'd0, in_ready, out_valid, free_p},
               {189'd0, 3'b100});
      @(negedge clk);
    end

    // R10: vector offered during release is dropped
    for (int v = 0; v < 4; v++) begin
      in_valid = 1'b1;
      in_vld   = 16'h0001;
      in_tid   = tids_for(v);
      @(negedge clk);
    end
    in_vld = 16'hFFFF;
    in_tid = {16{8'hEE}};
    check_eq("R10 not ready in drain", {189'd0, in_ready, out_valid, free_p},
             {189'd0, 3'b011});
    @(negedge clk);
    in_valid = 1'b0;
    check_eq("R10 ready again", {191'd0, in_ready}, {191'd0, 1'b1});
    run_scen(1, 64'h0000_0000_0000_0002, "R10 dropped vector absent");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule